// File: doc/BRIEF.md
# Bus Ownership Controller for a Shared-Bus Master

This block sits inside a bus master that shares one system bus with other masters through an external arbiter. It turns the master's internal "access pending" indication into a bus request, waits for a grant and for the previous owner to leave the bus, and then gives the master permission to start each transfer. It drives the bus-busy line for as long as it holds the bus.

Ownership is given up at a cycle boundary once the grant is withdrawn. A four-beat line transfer with bursting inhibited counts as one indivisible cycle. A locked read-modify-write sequence either yields to a withdrawn grant after the current cycle or keeps the bus until the whole sequence is done. A separate yield-control input selects which of the two applies.

The controller watches the shared transfer-start line, so it knows when another master has a cycle in flight. Every state change is qualified by a clock-enable input sampled on the rising clock edge.

Top module: `bus_own_ctl`

## Requirements
- R1: After reset, with no access pending, `req_o`, `busy_o` and `start_o` are all 0.
- R2: `req_o` equals `acc_pend` in every cycle, with no delay, whatever the grant and busy inputs are.
- R3: `start_o` is 0 while the bus is not held and either `grant_i` is 0 or `busy_i` is 1. When grant is present, `busy_i` is 0 and an access is pending, `start_o` is 1.
- R4: With grant already present and the bus idle, `start_o` goes high in the same cycle as `req_o` first rises.
- R5: While a transfer is in progress, `start_o` stays 0 even if another access is pending.
- R6: `busy_o` is 1 from the cycle of a start through the whole tenure, including idle owned cycles while grant stays high. It is 0 in the cycle after the bus is let go.
- R7: If `grant_i` is 0 at the edge where a single transfer terminates, `busy_o` is 0 in the next cycle.
- R8: When `acc_line`=1 at start, the transfer ends only on the fourth `ack_i`. A grant withdrawn earlier keeps `busy_o` at 1 until that fourth edge.
- R9: When `lock_more`=1 and `lock_yield`=1, a withdrawn grant releases the bus after the current transfer.
- R10: When `lock_more`=1 and `lock_yield`=0, a withdrawn grant is ignored. The master keeps the bus and may start further transfers until a transfer ends with `lock_more`=0, and it releases after that one.
- R11: `rty_i` or `err_i` ends the current transfer at once. After a retry with grant kept, a still-pending access is started again.
- R12: After `ts_i`=1 from another master, no start is given until a termination strobe (`ack_i`, `err_i` or `rty_i`) for that foreign cycle has been sampled.
- R13: While `clk_en`=0, `start_o` is 0 and no state changes. A termination strobe present then has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock-enable qualifier for all state changes |
| acc_pend | input | 1 | Internal access waiting for the bus |
| acc_line | input | 1 | Pending access is a four-beat non-burst line transfer |
| lock_more | input | 1 | Current transfer belongs to a locked sequence with more transfers to follow |
| lock_yield | input | 1 | 1: obey a grant withdrawal inside a locked sequence |
| grant_i | input | 1 | Grant from the external arbiter |
| busy_i | input | 1 | Bus-busy driven by other masters |
| ts_i | input | 1 | Transfer start seen on the shared bus from another master |
| ack_i | input | 1 | Transfer acknowledge (one beat) |
| err_i | input | 1 | Transfer error termination |
| rty_i | input | 1 | Transfer retry termination |
| req_o | output | 1 | Bus request to the arbiter |
| busy_o | output | 1 | Bus-busy drive for this master's tenure |
| start_o | output | 1 | Permission to start a transfer in this cycle |

## Verification
The assertions assume that each transfer ends on exactly one of acknowledge, error or retry. They also assume that `ts_i` reflects only other masters' starts, and that `busy_i` and a foreign start never appear while this master holds the bus. The bench drives inputs on the falling edge and raises at most one termination strobe at a time. It asserts `ts_i` and `busy_i` only while the controller is idle or requesting, and it holds `acc_line` and the lock inputs steady around the edges where the controller samples them.

// File: rtl/obc_pkg.sv
package obc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_PARK = 3'd2,
        ST_XFER = 3'd3,
        ST_DROP = 3'd4
    } own_st_e;

    typedef struct packed {
        own_st_e st;
        logic    hold;
    } ctl_s;

endpackage

// File: rtl/obc_keep_rule.sv
module obc_keep_rule (
    input  logic grant,
    input  logic lock_on,
    input  logic yield,
    output logic keep
);
    // Ownership survives a withdrawn grant only inside a lock that refuses to yield.
    assign keep = grant || (lock_on && !yield);
endmodule

// File: rtl/obc_beat_track.sv
module obc_beat_track #(
    parameter int LINE_BEATS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic start,
    input  logic line_in,
    input  logic active,
    input  logic ack,
    input  logic err,
    input  logic rty,
    output logic cycle_end
);
    localparam int BW = (LINE_BEATS > 2) ? $clog2(LINE_BEATS) : 1;
    localparam logic [BW-1:0] LAST = BW'(LINE_BEATS - 1);

    typedef struct packed {
        logic          line;
        logic [BW-1:0] beat;
    } bt_s;

    bt_s bt_d, bt_q;

    assign cycle_end = active && (err || rty || (ack && (!bt_q.line || bt_q.beat == LAST)));

    always_comb begin
        bt_d = bt_q;
        if (clk_en) begin
            if (start) begin
                bt_d.line = line_in;
                bt_d.beat = '0;
            end else if (active && ack && !cycle_end) begin
                bt_d.beat = bt_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bt_q <= '0;
        end else begin
            bt_q <= bt_d;
        end
    end
endmodule

// File: rtl/obc_foreign_watch.sv
module obc_foreign_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic ts,
    input  logic mine,
    input  logic term,
    output logic foreign_q
);
    logic foreign_d;

    always_comb begin
        foreign_d = foreign_q;
        if (clk_en && !mine) begin
            if (ts) begin
                foreign_d = 1'b1;
            end else if (term) begin
                foreign_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreign_q <= 1'b0;
        end else begin
            foreign_q <= foreign_d;
        end
    end
endmodule

// File: rtl/bus_own_ctl.sv
module bus_own_ctl #(
    parameter int LINE_BEATS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic acc_pend,
    input  logic acc_line,
    input  logic lock_more,
    input  logic lock_yield,
    input  logic grant_i,
    input  logic busy_i,
    input  logic ts_i,
    input  logic ack_i,
    input  logic err_i,
    input  logic rty_i,
    output logic req_o,
    output logic busy_o,
    output logic start_o
);
    import obc_pkg::*;

    ctl_s ctl_d, ctl_q;
    logic may_start;
    logic owner;
    logic cycle_end;
    logic foreign_q;
    logic keep_end;
    logic keep_park;
    logic any_term;

    assign owner    = (ctl_q.st == ST_PARK) || (ctl_q.st == ST_XFER);
    assign any_term = ack_i || err_i || rty_i;

    obc_beat_track #(.LINE_BEATS(LINE_BEATS)) u_beats (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .start     (start_o),
        .line_in   (acc_line),
        .active    (ctl_q.st == ST_XFER),
        .ack       (ack_i),
        .err       (err_i),
        .rty       (rty_i),
        .cycle_end (cycle_end)
    );

    obc_foreign_watch u_foreign (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .ts        (ts_i),
        .mine      (owner || start_o),
        .term      (any_term),
        .foreign_q (foreign_q)
    );

    obc_keep_rule u_keep_end (
        .grant   (grant_i),
        .lock_on (lock_more),
        .yield   (lock_yield),
        .keep    (keep_end)
    );

    obc_keep_rule u_keep_park (
        .grant   (grant_i),
        .lock_on (ctl_q.hold),
        .yield   (lock_yield),
        .keep    (keep_park)
    );

    always_comb begin
        case (ctl_q.st)
            ST_IDLE, ST_REQ: may_start = acc_pend && grant_i && !busy_i && !foreign_q;
            ST_PARK:         may_start = acc_pend && keep_park;
            default:         may_start = 1'b0;
        endcase
    end

    assign start_o = clk_en && may_start;
    assign req_o   = acc_pend;
    assign busy_o  = owner || start_o;

    always_comb begin
        ctl_d = ctl_q;
        if (clk_en) begin
            case (ctl_q.st)
                ST_IDLE: begin
                    if (may_start)     ctl_d.st = ST_XFER;
                    else if (acc_pend) ctl_d.st = ST_REQ;
                end
                ST_REQ: begin
                    if (may_start)      ctl_d.st = ST_XFER;
                    else if (!acc_pend) ctl_d.st = ST_IDLE;
                end
                ST_PARK: begin
                    if (may_start) begin
                        ctl_d.st = ST_XFER;
                    end else if (!keep_park) begin
                        ctl_d.st   = ST_DROP;
                        ctl_d.hold = 1'b0;
                    end
                end
                ST_XFER: begin
                    if (cycle_end) begin
                        if (keep_end) begin
                            ctl_d.st   = ST_PARK;
                            ctl_d.hold = lock_more;
                        end else begin
                            ctl_d.st   = ST_DROP;
                            ctl_d.hold = 1'b0;
                        end
                    end
                end
                default: begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.hold = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, hold: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/bus_own_ctl_chk.sv
module bus_own_ctl_chk (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              acc_pend,
    input logic              busy_i,
    input logic              foreign,
    input obc_pkg::own_st_e  st,
    input logic              start_o,
    input logic              busy_o
);
    import obc_pkg::*;

    a_r3_start_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (acc_pend && clk_en));

    a_r5_no_start_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_XFER) |-> !start_o);

    a_r6_busy_in_tenure: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_XFER || st == ST_PARK) |-> busy_o);

    a_r6_busy_low_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DROP) |-> !busy_o);

    a_r12_no_start_on_foreign: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_IDLE || st == ST_REQ) && (busy_i || foreign)) |-> !start_o);

    a_r13_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> (st == $past(st)));
endmodule

bind bus_own_ctl bus_own_ctl_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .acc_pend (acc_pend),
    .busy_i   (busy_i),
    .foreign  (foreign_q),
    .st       (ctl_q.st),
    .start_o  (start_o),
    .busy_o   (busy_o)
);

// File: tb/test_bus_own_ctl.sv
module test_bus_own_ctl;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_en = 1'b1;
    logic acc_pend = 1'b0, acc_line = 1'b0, lock_more = 1'b0, lock_yield = 1'b0;
    logic grant_i = 1'b0, busy_i = 1'b0, ts_i = 1'b0;
    logic ack_i = 1'b0, err_i = 1'b0, rty_i = 1'b0;
    logic req_o, busy_o, start_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    bus_own_ctl i_bus_own_ctl (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .acc_pend(acc_pend),
        .acc_line(acc_line), .lock_more(lock_more), .lock_yield(lock_yield),
        .grant_i(grant_i), .busy_i(busy_i), .ts_i(ts_i), .ack_i(ack_i),
        .err_i(err_i), .rty_i(rty_i), .req_o(req_o), .busy_o(busy_o),
        .start_o(start_o)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) cyc();
        #1;
        chk("R1", "req in reset", req_o, 1'b0);
        chk("R1", "busy in reset", busy_o, 1'b0);
        rst_n = 1'b1;
        cyc(); #1;
        chk("R1", "busy after reset", busy_o, 1'b0);
        chk("R1", "start after reset", start_o, 1'b0);
    endtask

    task automatic t_immediate();
        cyc(); grant_i = 1; acc_pend = 1; #1;
        chk("R2", "req follows pend", req_o, 1'b1);
        chk("R4", "same-cycle start", start_o, 1'b1);
        chk("R6", "busy at start", busy_o, 1'b1);
        cyc(); acc_pend = 0; #1;
        chk("R5", "no start in transfer", start_o, 1'b0);
        chk("R6", "busy in transfer", busy_o, 1'b1);
        cyc(); ack_i = 1; #1;
        chk("R6", "busy on ack", busy_o, 1'b1);
        cyc(); ack_i = 0; #1;
        chk("R6", "busy while parked", busy_o, 1'b1);
        cyc(); grant_i = 0; #1;
        chk("R6", "busy before drop edge", busy_o, 1'b1);
        cyc(); #1;
        chk("R6", "busy low after release", busy_o, 1'b0);
        cyc();
    endtask

    task automatic t_wait_grant();
        cyc(); acc_pend = 1; grant_i = 0; #1;
        chk("R3", "no start without grant", start_o, 1'b0);
        chk("R2", "req without grant", req_o, 1'b1);
        cyc(); #1;
        chk("R3", "still waiting", start_o, 1'b0);
        cyc(); acc_pend = 0; #1;
        chk("R2", "req dropped at once", req_o, 1'b0);
        cyc(); acc_pend = 1; busy_i = 1; grant_i = 1; #1;
        chk("R3", "no start while bus busy", start_o, 1'b0);
        cyc(); busy_i = 0; #1;
        chk("R3", "start once bus free", start_o, 1'b1);
        cyc(); acc_pend = 0; #1;
        chk("R6", "busy in transfer", busy_o, 1'b1);
        cyc(); ack_i = 1; grant_i = 0; #1;
        chk("R7", "busy held on final ack", busy_o, 1'b1);
        cyc(); ack_i = 0; #1;
        chk("R7", "released after cycle", busy_o, 1'b0);
        cyc();
    endtask

    task automatic t_line();
        cyc(); grant_i = 1; acc_pend = 1; acc_line = 1; #1;
        chk("R8", "line start", start_o, 1'b1);
        cyc(); acc_pend = 0; acc_line = 0; grant_i = 0; ack_i = 1; #1;
        chk("R8", "busy beat 1", busy_o, 1'b1);
        cyc(); #1;
        chk("R8", "busy after beat 1", busy_o, 1'b1);
        cyc(); #1;
        chk("R8", "busy after beat 2", busy_o, 1'b1);
        cyc(); #1;
        chk("R8", "busy after beat 3", busy_o, 1'b1);
        cyc(); ack_i = 0; #1;
        chk("R8", "released after beat 4", busy_o, 1'b0);
        cyc();
    endtask

    task automatic t_lock_yield();
        cyc(); grant_i = 1; acc_pend = 1; lock_more = 1; lock_yield = 1; #1;
        chk("R9", "locked start", start_o, 1'b1);
        cyc(); acc_pend = 0; grant_i = 0; #1;
        chk("R9", "busy in locked transfer", busy_o, 1'b1);
        cyc(); ack_i = 1; #1;
        chk("R9", "busy on ack", busy_o, 1'b1);
        cyc(); ack_i = 0; #1;
        chk("R9", "yielded after transfer", busy_o, 1'b0);
        cyc(); lock_more = 0; lock_yield = 0;
    endtask

    task automatic t_lock_hold();
        cyc(); grant_i = 1; acc_pend = 1; lock_more = 1; lock_yield = 0; #1;
        chk("R10", "locked start", start_o, 1'b1);
        cyc(); acc_pend = 0; grant_i = 0; #1;
        chk("R10", "busy in transfer", busy_o, 1'b1);
        cyc(); ack_i = 1; #1;
        chk("R10", "busy on ack", busy_o, 1'b1);
        cyc(); ack_i = 0; #1;
        chk("R10", "bus kept without grant", busy_o, 1'b1);
        cyc(); acc_pend = 1; lock_more = 0; #1;
        chk("R10", "last locked start without grant", start_o, 1'b1);
        cyc(); acc_pend = 0; #1;
        chk("R10", "busy in last transfer", busy_o, 1'b1);
        cyc(); ack_i = 1; #1;
        chk("R10", "busy on last ack", busy_o, 1'b1);
        cyc(); ack_i = 0; #1;
        chk("R10", "released after lock", busy_o, 1'b0);
        cyc();
    endtask

    task automatic t_retry();
        cyc(); grant_i = 1; acc_pend = 1; #1;
        chk("R11", "first start", start_o, 1'b1);
        cyc(); rty_i = 1; #1;
        chk("R11", "no start during retried transfer", start_o, 1'b0);
        chk("R11", "request held for retry", req_o, 1'b1);
        cyc(); rty_i = 0; #1;
        chk("R11", "restart after retry", start_o, 1'b1);
        cyc(); err_i = 1; grant_i = 0; acc_pend = 0; #1;
        chk("R11", "busy on error", busy_o, 1'b1);
        cyc(); err_i = 0; #1;
        chk("R11", "error ends transfer", busy_o, 1'b0);
        cyc();
    endtask

    task automatic t_foreign();
        cyc(); ts_i = 1; #1;
        chk("R12", "no start at foreign ts", start_o, 1'b0);
        cyc(); ts_i = 0; grant_i = 1; acc_pend = 1; #1;
        chk("R12", "blocked by foreign cycle", start_o, 1'b0);
        cyc(); #1;
        chk("R12", "still blocked", start_o, 1'b0);
        cyc(); ack_i = 1; #1;
        chk("R12", "blocked on foreign ack", start_o, 1'b0);
        cyc(); ack_i = 0; #1;
        chk("R12", "start after foreign end", start_o, 1'b1);
        cyc(); acc_pend = 0; #1;
        cyc(); ack_i = 1; grant_i = 0; #1;
        cyc(); ack_i = 0; #1;
        chk("R12", "own cycle released", busy_o, 1'b0);
        cyc();
    endtask

    task automatic t_clken();
        cyc(); clk_en = 0; grant_i = 1; acc_pend = 1; #1;
        chk("R13", "no start when disabled", start_o, 1'b0);
        chk("R2", "req while disabled", req_o, 1'b1);
        cyc(); #1;
        chk("R13", "still idle", busy_o, 1'b0);
        cyc(); clk_en = 1; #1;
        chk("R13", "start when enabled", start_o, 1'b1);
        cyc(); acc_pend = 0; #1;
        chk("R13", "busy in transfer", busy_o, 1'b1);
        cyc(); clk_en = 0; ack_i = 1; grant_i = 0; #1;
        chk("R13", "busy with ack disabled", busy_o, 1'b1);
        cyc(); #1;
        chk("R13", "ack ignored while disabled", busy_o, 1'b1);
        cyc(); clk_en = 1; #1;
        chk("R13", "busy at enabled ack", busy_o, 1'b1);
        cyc(); ack_i = 0; #1;
        chk("R13", "released after enabled ack", busy_o, 1'b0);
        cyc();
    endtask

    initial begin
        t_reset();
        t_immediate();
        t_wait_grant();
        t_line();
        t_lock_yield();
        t_lock_hold();
        t_retry();
        t_foreign();
        t_clken();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 5000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule